// File: doc/BRIEF.md
# Unified Data-Space Address Decoder

This block is the data-memory front end of a small 8-bit processor core. It places three storage regions under one 16-bit byte address space. The lowest 32 addresses are the CPU's own 8-bit working registers. The next 64 addresses are the I/O register block. Everything from address 0x0060 up to the top of the implemented scratch RAM is general-purpose SRAM. With the default 2048 bytes of SRAM, the space spans 2144 bytes.

Several ports reach the same storage. A load/store port addresses the whole data space. A short 6-bit I/O port reaches the I/O block directly: I/O address n is the same register as data address n + 0x20. Two combinational read ports deliver ALU operands from the register file, and a writeback port stores ALU results into it. The three 16-bit indirect pointers are always available as outputs, each built from a register pair. The flag byte and the stack pointer are also tapped from their fixed I/O locations.

All reads are combinational from the current state. All writes take effect at the rising clock edge, so a value written through any port can be read through every other port in the following cycle.

Top module: `dspace_front`

## Requirements
- R1: A synchronous active-high reset clears all 32 working registers and all 64 I/O registers to 0x00, so every pointer, flag and stack output reads zero. SRAM contents survive reset.
- R2: Data addresses 0x0000 to 0x001F select working register (address) for load and store, and these are the same registers seen by the operand read ports.
- R3: Data addresses 0x0020 to 0x005F select I/O register (address − 0x20). The 6-bit I/O port at address n reaches the same register as data address n + 0x20, for both reads and writes.
- R4: Data addresses from 0x0060 to 0x0060 + SRAM_BYTES − 1 select SRAM byte (address − 0x0060). With the default size, both 0x0060 and 0x085F store and return bytes.
- R5: A data address at or above 0x0060 + SRAM_BYTES reads as 0x00, and a store there changes no location.
- R6: ptr_x is {R27,R26}, ptr_y is {R29,R28} and ptr_z is {R31,R30}, with the even register as the low byte.
- R7: flags_out mirrors I/O register 0x3F (data 0x5F). stack_ptr is {I/O 0x3E, I/O 0x3D}, with 0x3D as the low byte.
- R8: When the writeback port and a load/store write hit the same working register in one cycle, the writeback value is kept. Writes to different registers in one cycle both take effect.
- R9: When a load/store write and an I/O-port write hit the same I/O register in one cycle, the load/store value is kept. Writes to different I/O registers in one cycle both take effect.
- R10: A write through any port is visible on the next cycle's read through every other port that maps the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ds_addr | input | 16 | Load/store byte address |
| ds_wr_en | input | 1 | Load/store write strobe |
| ds_wdata | input | 8 | Load/store write data |
| ds_rdata | output | 8 | Load/store read data (combinational) |
| io_addr | input | 6 | Short I/O-port address |
| io_wr_en | input | 1 | I/O-port write strobe |
| io_wdata | input | 8 | I/O-port write data |
| io_rdata | output | 8 | I/O-port read data (combinational) |
| opa_sel | input | 5 | Operand A register select |
| opa_data | output | 8 | Operand A value |
| opb_sel | input | 5 | Operand B register select |
| opb_data | output | 8 | Operand B value |
| wb_en | input | 1 | Register writeback strobe |
| wb_sel | input | 5 | Writeback register select |
| wb_data | input | 8 | Writeback value |
| ptr_x | output | 16 | Pointer from R27:R26 |
| ptr_y | output | 16 | Pointer from R29:R28 |
| ptr_z | output | 16 | Pointer from R31:R30 |
| flags_out | output | 8 | Flag byte at I/O 0x3F |
| stack_ptr | output | 16 | Stack pointer at I/O 0x3E:0x3D |

## Verification
Two pairs of functions can land in the same cycle. A load/store write can meet a writeback write at one working register, and a load/store write can meet an I/O-port write at one I/O register. The bench provokes each collision by raising both strobes in a single cycle, first on the same target and then on different targets. In the next cycle it reads the targets back through a third window: the operand port for registers, and the opposite address window for I/O registers. A same-target collision is judged correct only if the higher-priority value is read back, and a different-target pair only if both values are read back.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

    localparam int DW          = 8;
    localparam int AW          = 16;
    localparam int REG_COUNT   = 32;
    localparam int IO_COUNT    = 64;
    localparam int REG_SW      = $clog2(REG_COUNT);
    localparam int IO_SW       = $clog2(IO_COUNT);
    localparam int IO_BASE     = REG_COUNT;
    localparam int RAM_BASE    = REG_COUNT + IO_COUNT;
    localparam int PTR_COUNT   = 3;
    localparam int PTR_BASE    = 26;
    localparam int FLAGS_IDX   = 63;
    localparam int SPL_IDX     = 61;
    localparam int SPH_IDX     = 62;

    typedef enum logic [1:0] {
        RGN_REG  = 2'd0,
        RGN_IO   = 2'd1,
        RGN_RAM  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef struct packed {
        region_e         region;
        logic [AW-1:0]   offset;
    } ds_decode_t;

    function automatic ds_decode_t decode_addr(input logic [AW-1:0] a,
                                               input int unsigned ram_bytes);
        ds_decode_t d;
        if (32'(a) < IO_BASE) begin
            d.region = RGN_REG;
            d.offset = a;
        end else if (32'(a) < RAM_BASE) begin
            d.region = RGN_IO;
            d.offset = a - AW'(IO_BASE);
        end else if (32'(a) < RAM_BASE + ram_bytes) begin
            d.region = RGN_RAM;
            d.offset = a - AW'(RAM_BASE);
        end else begin
            d.region = RGN_NONE;
            d.offset = '0;
        end
        return d;
    endfunction

endpackage

// File: rtl/dsf_decoder.sv
module dsf_decoder
    import dspace_pkg::*;
#(
    parameter int SRAM_BYTES = 2048
) (
    input  logic [AW-1:0] addr,
    output ds_decode_t    dec
);
    always_comb dec = decode_addr(addr, SRAM_BYTES);
endmodule

// File: rtl/dsf_reg_bank.sv
module dsf_reg_bank
    import dspace_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wa_en,
    input  logic [REG_SW-1:0] wa_sel,
    input  logic [DW-1:0]     wa_data,
    input  logic              wb_en,
    input  logic [REG_SW-1:0] wb_sel,
    input  logic [DW-1:0]     wb_data,
    input  logic [REG_SW-1:0] rd_a_sel,
    output logic [DW-1:0]     rd_a,
    input  logic [REG_SW-1:0] rd_b_sel,
    output logic [DW-1:0]     rd_b,
    input  logic [REG_SW-1:0] rd_c_sel,
    output logic [DW-1:0]     rd_c,
    output logic [PTR_COUNT-1:0][2*DW-1:0] ptrs
);
    logic [DW-1:0] regs [REG_COUNT];

    // port A is assigned last, so it wins a same-register collision
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
        end else begin
            if (wb_en) regs[wb_sel] <= wb_data;
            if (wa_en) regs[wa_sel] <= wa_data;
        end
    end

    assign rd_a = regs[rd_a_sel];
    assign rd_b = regs[rd_b_sel];
    assign rd_c = regs[rd_c_sel];

    for (genvar p = 0; p < PTR_COUNT; p++) begin : g_ptr
        localparam int LO = PTR_BASE + 2 * p;
        assign ptrs[p] = {regs[LO+1], regs[LO]};
    end
endmodule

// File: rtl/dsf_io_bank.sv
module dsf_io_bank
    import dspace_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pa_en,
    input  logic [IO_SW-1:0] pa_sel,
    input  logic [DW-1:0]    pa_data,
    input  logic             pb_en,
    input  logic [IO_SW-1:0] pb_sel,
    input  logic [DW-1:0]    pb_data,
    input  logic [IO_SW-1:0] rd_a_sel,
    output logic [DW-1:0]    rd_a,
    input  logic [IO_SW-1:0] rd_b_sel,
    output logic [DW-1:0]    rd_b,
    output logic [DW-1:0]    flags,
    output logic [2*DW-1:0]  sp
);
    logic [DW-1:0] regs [IO_COUNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < IO_COUNT; i++) regs[i] <= '0;
        end else begin
            if (pb_en) regs[pb_sel] <= pb_data;
            if (pa_en) regs[pa_sel] <= pa_data;
        end
    end

    assign rd_a  = regs[rd_a_sel];
    assign rd_b  = regs[rd_b_sel];
    assign flags = regs[FLAGS_IDX];
    assign sp    = {regs[SPH_IDX], regs[SPL_IDX]};
endmodule

// File: rtl/dsf_sram.sv
module dsf_sram
    import dspace_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/dspace_front.sv
module dspace_front
    import dspace_pkg::*;
#(
    parameter int SRAM_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] ds_addr,
    input  logic        ds_wr_en,
    input  logic [7:0]  ds_wdata,
    output logic [7:0]  ds_rdata,
    input  logic [5:0]  io_addr,
    input  logic        io_wr_en,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic [4:0]  opa_sel,
    output logic [7:0]  opa_data,
    input  logic [4:0]  opb_sel,
    output logic [7:0]  opb_data,
    input  logic        wb_en,
    input  logic [4:0]  wb_sel,
    input  logic [7:0]  wb_data,
    output logic [15:0] ptr_x,
    output logic [15:0] ptr_y,
    output logic [15:0] ptr_z,
    output logic [7:0]  flags_out,
    output logic [15:0] stack_ptr
);
    localparam int RAM_AW = $clog2(SRAM_BYTES);

    ds_decode_t dec;
    logic [DW-1:0] reg_ds_rd, io_ds_rd, ram_rd;
    logic [PTR_COUNT-1:0][2*DW-1:0] ptrs;
    logic reg_we, io_we, ram_we;

    dsf_decoder #(.SRAM_BYTES(SRAM_BYTES)) u_dec (
        .addr (ds_addr),
        .dec  (dec)
    );

    assign reg_we = ds_wr_en && (dec.region == RGN_REG);
    assign io_we  = ds_wr_en && (dec.region == RGN_IO);
    assign ram_we = ds_wr_en && (dec.region == RGN_RAM) && !rst;

    // writeback takes the priority port of the register file
    dsf_reg_bank u_regs (
        .clk      (clk),
        .rst      (rst),
        .wa_en    (wb_en),
        .wa_sel   (wb_sel),
        .wa_data  (wb_data),
        .wb_en    (reg_we),
        .wb_sel   (dec.offset[REG_SW-1:0]),
        .wb_data  (ds_wdata),
        .rd_a_sel (opa_sel),
        .rd_a     (opa_data),
        .rd_b_sel (opb_sel),
        .rd_b     (opb_data),
        .rd_c_sel (dec.offset[REG_SW-1:0]),
        .rd_c     (reg_ds_rd),
        .ptrs     (ptrs)
    );

    // load/store takes the priority port of the I/O block
    dsf_io_bank u_io (
        .clk      (clk),
        .rst      (rst),
        .pa_en    (io_we),
        .pa_sel   (dec.offset[IO_SW-1:0]),
        .pa_data  (ds_wdata),
        .pb_en    (io_wr_en),
        .pb_sel   (io_addr),
        .pb_data  (io_wdata),
        .rd_a_sel (dec.offset[IO_SW-1:0]),
        .rd_a     (io_ds_rd),
        .rd_b_sel (io_addr),
        .rd_b     (io_rdata),
        .flags    (flags_out),
        .sp       (stack_ptr)
    );

    dsf_sram #(.DEPTH(SRAM_BYTES)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (dec.offset[RAM_AW-1:0]),
        .wdata (ds_wdata),
        .rdata (ram_rd)
    );

    always_comb begin
        unique case (dec.region)
            RGN_REG: ds_rdata = reg_ds_rd;
            RGN_IO:  ds_rdata = io_ds_rd;
            RGN_RAM: ds_rdata = ram_rd;
            default: ds_rdata = '0;
        endcase
    end

    assign ptr_x = ptrs[0];
    assign ptr_y = ptrs[1];
    assign ptr_z = ptrs[2];
endmodule

// File: rtl/dspace_front_chk.sv
module dspace_front_chk #(
    parameter int SRAM_BYTES = 2048
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] ds_addr,
    input logic        ds_wr_en,
    input logic [7:0]  ds_wdata,
    input logic [7:0]  ds_rdata,
    input logic [5:0]  io_addr,
    input logic        io_wr_en,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic [4:0]  opa_sel,
    input logic [7:0]  opa_data,
    input logic        wb_en,
    input logic [4:0]  wb_sel,
    input logic [7:0]  wb_data,
    input logic [15:0] ptr_x,
    input logic [15:0] ptr_y,
    input logic [15:0] ptr_z,
    input logic [7:0]  flags_out,
    input logic [15:0] stack_ptr
);
    localparam logic [16:0] TOP = 17'(96 + SRAM_BYTES);

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (ptr_x == 16'h0 && ptr_y == 16'h0 && ptr_z == 16'h0
                        && flags_out == 8'h0 && stack_ptr == 16'h0));

    p_io_alias_r3: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, ds_addr} == {11'd0, io_addr} + 17'h20) |-> (ds_rdata == io_rdata));

    p_beyond_top_r5: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, ds_addr} >= TOP) |-> (ds_rdata == 8'h00));

    p_xlow_r6: assert property (@(posedge clk) disable iff (rst)
        (opa_sel == 5'd26) |-> (opa_data == ptr_x[7:0]));

    p_zhigh_r6: assert property (@(posedge clk) disable iff (rst)
        (opa_sel == 5'd31) |-> (opa_data == ptr_z[15:8]));

    p_flags_tap_r7: assert property (@(posedge clk) disable iff (rst)
        (io_addr == 6'h3F) |-> (io_rdata == flags_out));

    p_wb_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (wb_en && ds_wr_en && ds_addr == {11'd0, wb_sel})
        |=> (opa_sel != $past(wb_sel) || opa_data == $past(wb_data)));

    p_ds_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (ds_wr_en && io_wr_en && ds_addr == {10'd0, io_addr} + 16'h20)
        |=> (io_addr != $past(io_addr) || io_rdata == $past(ds_wdata)));
endmodule

bind dspace_front dspace_front_chk #(.SRAM_BYTES(SRAM_BYTES)) u_chk (
    .clk(clk), .rst(rst), .ds_addr(ds_addr), .ds_wr_en(ds_wr_en),
    .ds_wdata(ds_wdata), .ds_rdata(ds_rdata), .io_addr(io_addr),
    .io_wr_en(io_wr_en), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .opa_sel(opa_sel), .opa_data(opa_data), .wb_en(wb_en), .wb_sel(wb_sel),
    .wb_data(wb_data), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .flags_out(flags_out), .stack_ptr(stack_ptr)
);

// File: tb/sim_dspace_front.sv
module sim_dspace_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ds_addr = '0;
    logic        ds_wr_en = 1'b0;
    logic [7:0]  ds_wdata = '0;
    logic [7:0]  ds_rdata;
    logic [5:0]  io_addr = '0;
    logic        io_wr_en = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [4:0]  opa_sel = '0, opb_sel = '0, wb_sel = '0;
    logic [7:0]  opa_data, opb_data, wb_data = '0;
    logic        wb_en = 1'b0;
    logic [15:0] ptr_x, ptr_y, ptr_z, stack_ptr;
    logic [7:0]  flags_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dspace_front u0 (
        .clk(clk), .rst(rst), .ds_addr(ds_addr), .ds_wr_en(ds_wr_en),
        .ds_wdata(ds_wdata), .ds_rdata(ds_rdata), .io_addr(io_addr),
        .io_wr_en(io_wr_en), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .opa_sel(opa_sel), .opa_data(opa_data), .opb_sel(opb_sel),
        .opb_data(opb_data), .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
        .flags_out(flags_out), .stack_ptr(stack_ptr)
    );

    // op: 0 load/store write, 1 load/store read+check, 2 I/O write, 3 I/O read+check
    localparam int NV = 20;
    localparam logic [37:0] VEC [NV] = '{
        {2'd0, 4'd2,  16'h0005, 8'hA5, 8'h00},  // R2
        {2'd1, 4'd2,  16'h0005, 8'h00, 8'hA5},  // R2
        {2'd0, 4'd3,  16'h0025, 8'h3C, 8'h00},  // R3
        {2'd3, 4'd3,  16'h0005, 8'h00, 8'h3C},  // R3
        {2'd2, 4'd3,  16'h0010, 8'h77, 8'h00},  // R3
        {2'd1, 4'd3,  16'h0030, 8'h00, 8'h77},  // R3
        {2'd0, 4'd4,  16'h0060, 8'h11, 8'h00},  // R4
        {2'd0, 4'd4,  16'h085F, 8'h22, 8'h00},  // R4
        {2'd0, 4'd4,  16'h07FF, 8'h99, 8'h00},  // R4
        {2'd1, 4'd4,  16'h0060, 8'h00, 8'h11},  // R4
        {2'd1, 4'd4,  16'h085F, 8'h00, 8'h22},  // R4
        {2'd0, 4'd5,  16'h0860, 8'hEE, 8'h00},  // R5
        {2'd1, 4'd5,  16'h0860, 8'h00, 8'h00},  // R5
        {2'd0, 4'd5,  16'hFFFF, 8'h55, 8'h00},  // R5
        {2'd1, 4'd5,  16'hFFFF, 8'h00, 8'h00},  // R5
        {2'd1, 4'd5,  16'h0060, 8'h00, 8'h11},  // R5
        {2'd1, 4'd5,  16'h07FF, 8'h00, 8'h99},  // R5
        {2'd1, 4'd5,  16'h085F, 8'h00, 8'h22},  // R5
        {2'd0, 4'd10, 16'h005F, 8'h81, 8'h00},  // R10
        {2'd3, 4'd10, 16'h003F, 8'h00, 8'h81}   // R10
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ds_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        ds_addr = a; ds_wdata = d; ds_wr_en = 1'b1;
        @(negedge clk);
        ds_wr_en = 1'b0;
    endtask

    task automatic io_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr_en = 1'b1;
        @(negedge clk);
        io_wr_en = 1'b0;
    endtask

    task automatic rf_write(input logic [4:0] s, input logic [7:0] d);
        @(negedge clk);
        wb_sel = s; wb_data = d; wb_en = 1'b1;
        @(negedge clk);
        wb_en = 1'b0;
    endtask

    task automatic ds_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        ds_addr = a;
        #2 d = ds_rdata;
    endtask

    task automatic io_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a;
        #2 d = io_rdata;
    endtask

    initial begin
        #4000000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 ptr_x", ptr_x, 16'h0);
        check("R1 stack", stack_ptr, 16'h0);
        check("R1 flags", {8'h0, flags_out}, 16'h0);
        ds_read(16'h0045, rd); check("R1 io reg", {8'h0, rd}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  tag;
            logic [15:0] a;
            logic [7:0]  d, e;
            {op, tag, a, d, e} = VEC[i];
            case (op)
                2'd0: ds_write(a, d);
                2'd2: io_write(a[5:0], d);
                2'd1: begin ds_read(a, rd);
                      check($sformatf("R%0d vec%0d", tag, i), {8'h0, rd}, {8'h0, e}); end
                default: begin io_read(a[5:0], rd);
                      check($sformatf("R%0d vec%0d", tag, i), {8'h0, rd}, {8'h0, e}); end
            endcase
        end

        // R2/R10: operand ports see load/store writes and vice versa
        @(negedge clk); opa_sel = 5'd5; opb_sel = 5'd5;
        #2 check("R2 opa", {8'h0, opa_data}, 16'h00A5);
        check("R2 opb", {8'h0, opb_data}, 16'h00A5);
        rf_write(5'd31, 8'h6B);
        ds_read(16'h001F, rd); check("R10 wb->ds", {8'h0, rd}, 16'h006B);

        // R6: pointer pairs
        rf_write(5'd26, 8'h34); rf_write(5'd27, 8'h12);
        ds_write(16'h001C, 8'hCD); ds_write(16'h001D, 8'hAB);
        rf_write(5'd30, 8'h78);
        #2 check("R6 x", ptr_x, 16'h1234);
        check("R6 y", ptr_y, 16'hABCD);
        check("R6 z", ptr_z, 16'h6B78);

        // R7: flag and stack taps
        check("R7 flags", {8'h0, flags_out}, 16'h0081);
        ds_write(16'h005D, 8'hFF); io_write(6'h3E, 8'h08);
        #2 check("R7 sp", stack_ptr, 16'h08FF);

        // R8: writeback vs load/store on one register, then on two
        @(negedge clk);
        wb_en = 1'b1; wb_sel = 5'd3; wb_data = 8'hC3;
        ds_wr_en = 1'b1; ds_addr = 16'h0003; ds_wdata = 8'h3D;
        @(negedge clk);
        wb_sel = 5'd4; wb_data = 8'h44; ds_addr = 16'h0006; ds_wdata = 8'h66;
        @(negedge clk);
        wb_en = 1'b0; ds_wr_en = 1'b0;
        opa_sel = 5'd3; opb_sel = 5'd4;
        #2 check("R8 same", {8'h0, opa_data}, 16'h00C3);
        check("R8 diff wb", {8'h0, opb_data}, 16'h0044);
        opa_sel = 5'd6;
        #2 check("R8 diff ds", {8'h0, opa_data}, 16'h0066);

        // R9: load/store vs I/O port on one I/O register, then on two
        @(negedge clk);
        ds_wr_en = 1'b1; ds_addr = 16'h0030; ds_wdata = 8'hAA;
        io_wr_en = 1'b1; io_addr = 6'h10; io_wdata = 8'hBB;
        @(negedge clk);
        ds_addr = 16'h0031; ds_wdata = 8'h01; io_addr = 6'h12; io_wdata = 8'h02;
        @(negedge clk);
        ds_wr_en = 1'b0; io_wr_en = 1'b0;
        io_read(6'h10, rd); check("R9 same", {8'h0, rd}, 16'h00AA);
        io_read(6'h11, rd); check("R9 diff ds", {8'h0, rd}, 16'h0001);
        ds_read(16'h0032, rd); check("R9 diff io", {8'h0, rd}, 16'h0002);

        // R1: second reset clears registers but keeps SRAM
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #2 check("R1 ptr after rst", ptr_x, 16'h0);
        check("R1 sp after rst", stack_ptr, 16'h0);
        io_read(6'h10, rd); check("R1 io after rst", {8'h0, rd}, 16'h0);
        ds_read(16'h0060, rd); check("R1 sram kept", {8'h0, rd}, 16'h0011);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule